// File: doc/BRIEF.md
# CAN Transmit Buffer Scheduler

This block tracks the transmit status of a set of CAN message buffers and tells the bit-level protocol engine which buffer it sends next. Software writes a two-bit mode into a buffer through a simple write port. The block turns buffers with a pending request into busy buffers by fixed priority, where the lowest index wins. It presents the chosen buffer as the next request and follows the engine's frame events through success, failure and recovery.

The choice of the next buffer is made early, from the start of the current frame's CRC field onward. Until the next frame starts, a pending buffer with a lower index can displace that choice, and software can cancel it. Buffers can also sit waiting for a matching remote frame. A match turns them into a one-shot request, and after it is sent the buffer goes back to waiting.

Each buffer's status is a three-bit field: bit 2 is the busy indication and bits [1:0] are the mode, where 0 is idle (not active), 1 is send once, 2 is wait for remote frame and 3 is send once then wait for remote frame. A busy buffer with mode 1 or 3 is the busy status (field value 5 or 7).

Top module: `can_tx_sched`

## Requirements
- R1: After reset every buffer status is 0, `nextValid` is 0 and `doneValid` is 0.
- R2: A write to a non-busy buffer loads bits [1:0] of `cpuWrData` into its mode one cycle later. Bit 2 of `cpuWrData` never changes the busy bit.
- R3: The selection window is open while no frame is in progress or after `crcStart`. In a window cycle that has no CPU write and no frame event, the lowest-index buffer with mode 1 or 3 and busy clear gets its busy bit set at the next edge, and `nextValid`=1 with `nextIdx` set to it.
- R4: Between an accepted `frameStart` and the following `crcStart`, no buffer is selected.
- R5: A pending buffer with a lower index than the scheduled one takes its place in a window cycle, and the displaced buffer returns to busy 0 with its mode kept. A pending buffer with a higher index does not take its place.
- R6: `frameStart` with `nextValid`=1 and no frame in progress moves `nextIdx` into `curIdx` and clears `nextValid`. Without a request it is ignored. During the CRC window at most two buffers, the current one and the scheduled one, are busy.
- R7: A write of mode 0 to the scheduled buffer before its frame starts cancels it: its status becomes 0 and `nextValid` clears. Any other write to a busy buffer, including the one being sent, is ignored.
- R8: On `txOk` the current buffer clears busy, and mode 1 becomes 0 while mode 3 becomes 2. `doneValid` pulses for one cycle with `doneIdx` set to that buffer.
- R9: On `txFail` every busy bit clears while modes are kept, and no selection happens until `recoverDone`. After that, selection runs again and the failed buffer is retried by priority.
- R10: `rtrMatch[i]` turns a non-busy buffer in mode 2 into mode 3. It has no effect on buffers in any other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuWrEn | input | 1 | Status write strobe |
| cpuWrIdx | input | IDX_W | Buffer written |
| cpuWrData | input | 3 | Written status; bit 2 ignored |
| crcStart | input | 1 | Current frame's CRC field begins |
| frameStart | input | 1 | Next frame transmission begins |
| txOk | input | 1 | Current frame sent successfully |
| txFail | input | 1 | Arbitration lost or transmit error |
| recoverDone | input | 1 | Interrupting reception or error signalling finished |
| rtrMatch | input | NUM_BUF | Remote frame accepted, per buffer |
| statusFlat | output | 3*NUM_BUF | Buffer i status at bits [3i+2:3i] |
| curIdx | output | IDX_W | Buffer being sent |
| nextIdx | output | IDX_W | Buffer scheduled next |
| nextValid | output | 1 | Next request valid |
| doneValid | output | 1 | One-cycle success pulse |
| doneIdx | output | IDX_W | Buffer that finished |

## Verification
The scheduling is exercised with several request patterns. A lone request while idle shows basic selection. A lower-index request arriving after a choice is made shows pre-emption. A higher-index request shows that no pre-emption happens in that case. A request raised during a frame shows the window closed before the CRC field and open after it. A cancel, a failure with recovery and retry, and a write aimed at the buffer being sent separate the cases where the choice is dropped, rerun or protected. A remote-frame loop, a direct send-then-wait write, and a match on a non-waiting buffer distinguish the return-to-wait path from the return-to-idle path.

// File: rtl/can_txs_pkg.sv
package can_txs_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE     = 2'd0,
    MODE_ONCE     = 2'd1,
    MODE_RTR      = 2'd2,
    MODE_ONCE_RTR = 2'd3
  } txMode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FRAME = 2'd1,
    SEQ_CRC   = 2'd2,
    SEQ_HALT  = 2'd3
  } seq_e;

  typedef struct packed {
    logic promote;
    logic demote;
    logic finish;
    logic abort;
    logic cpuWrite;
    logic cpuCancel;
  } strobes_t;

endpackage

// File: rtl/can_txs_datapath.sv
module can_txs_datapath
  import can_txs_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               strb,
  input  logic [IDX_W-1:0]       wrIdx,
  input  txMode_e                wrMode,
  input  logic [IDX_W-1:0]       curIdx,
  input  logic [IDX_W-1:0]       nextIdx,
  input  logic [NUM_BUF-1:0]     rtrMatch,
  output logic [3*NUM_BUF-1:0]   statusFlat,
  output logic [NUM_BUF-1:0]     busyVec,
  output logic                   candValid,
  output logic [IDX_W-1:0]       candIdx
);

  txMode_e modeQ [NUM_BUF];
  logic [NUM_BUF-1:0] busyQ;
  logic [NUM_BUF-1:0] pendVec;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[g] <= MODE_IDLE;
        busyQ[g] <= 1'b0;
      end else begin
        if (rtrMatch[g] && modeQ[g] == MODE_RTR && !busyQ[g] &&
            !(strb.cpuWrite && wrIdx == MY_IDX))
          modeQ[g] <= MODE_ONCE_RTR;
        if (strb.cpuWrite && wrIdx == MY_IDX)
          modeQ[g] <= wrMode;
        if (strb.cpuCancel && wrIdx == MY_IDX) begin
          modeQ[g] <= MODE_IDLE;
          busyQ[g] <= 1'b0;
        end
        if (strb.finish && curIdx == MY_IDX) begin
          busyQ[g] <= 1'b0;
          modeQ[g] <= (modeQ[g] == MODE_ONCE_RTR) ? MODE_RTR : MODE_IDLE;
        end
        if (strb.abort)
          busyQ[g] <= 1'b0;
        if (strb.demote && nextIdx == MY_IDX)
          busyQ[g] <= 1'b0;
        if (strb.promote && candIdx == MY_IDX)
          busyQ[g] <= 1'b1;
      end
    end

    assign pendVec[g] = (modeQ[g] == MODE_ONCE || modeQ[g] == MODE_ONCE_RTR) && !busyQ[g];
    assign statusFlat[3*g +: 3] = {busyQ[g], modeQ[g]};

    // R10: a waiting-for-remote buffer is never busy
    p_rtr_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[g] == MODE_RTR) |-> !busyQ[g]);
  end

  // fixed priority: lowest index wins
  always_comb begin
    candValid = 1'b0;
    candIdx   = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        candValid = 1'b1;
        candIdx   = IDX_W'(i);
      end
    end
  end

  assign busyVec = busyQ;

  // R6: at most the current and the scheduled buffer are busy
  p_busy_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(busyQ) <= 2);

endmodule

// File: rtl/can_txs_control.sv
module can_txs_control
  import can_txs_pkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuWrEn,
  input  logic [IDX_W-1:0]   cpuWrIdx,
  input  txMode_e            cpuWrMode,
  input  logic               crcStart,
  input  logic               frameStart,
  input  logic               txOk,
  input  logic               txFail,
  input  logic               recoverDone,
  input  logic [NUM_BUF-1:0] busyVec,
  input  logic               candValid,
  input  logic [IDX_W-1:0]   candIdx,
  output strobes_t           strb,
  output logic [IDX_W-1:0]   curIdx,
  output logic [IDX_W-1:0]   nextIdx,
  output logic               nextValid,
  output logic               doneValid,
  output logic [IDX_W-1:0]   doneIdx
);

  seq_e seqQ;
  logic inFrame, winOpen, anyEvt, startNow, okNow, abortNow, wrBusy, selOk;

  assign inFrame  = (seqQ == SEQ_FRAME) || (seqQ == SEQ_CRC);
  assign winOpen  = (seqQ == SEQ_IDLE) || (seqQ == SEQ_CRC);
  assign anyEvt   = crcStart | frameStart | txOk | txFail | recoverDone;
  assign startNow = (seqQ == SEQ_IDLE) && frameStart && nextValid;
  assign okNow    = inFrame && txOk && !txFail;
  assign abortNow = inFrame && txFail;
  assign wrBusy   = busyVec[cpuWrIdx];
  assign selOk    = winOpen && !anyEvt && !cpuWrEn && candValid;

  always_comb begin
    strb           = '0;
    strb.cpuWrite  = cpuWrEn && !wrBusy;
    strb.cpuCancel = cpuWrEn && wrBusy && nextValid && (cpuWrIdx == nextIdx) &&
                     (cpuWrMode == MODE_IDLE) && !startNow && !abortNow;
    strb.promote   = selOk && (!nextValid || candIdx < nextIdx);
    strb.demote    = strb.promote && nextValid;
    strb.finish    = okNow;
    strb.abort     = abortNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ      <= SEQ_IDLE;
      curIdx    <= '0;
      nextIdx   <= '0;
      nextValid <= 1'b0;
      doneValid <= 1'b0;
      doneIdx   <= '0;
    end else begin
      doneValid <= okNow;
      if (okNow) doneIdx <= curIdx;

      case (seqQ)
        SEQ_IDLE:  if (startNow) begin
                     seqQ   <= SEQ_FRAME;
                     curIdx <= nextIdx;
                   end
        SEQ_FRAME: if (abortNow) seqQ <= SEQ_HALT;
                   else if (okNow) seqQ <= SEQ_IDLE;
                   else if (crcStart) seqQ <= SEQ_CRC;
        SEQ_CRC:   if (abortNow) seqQ <= SEQ_HALT;
                   else if (okNow) seqQ <= SEQ_IDLE;
        SEQ_HALT:  if (recoverDone) seqQ <= SEQ_IDLE;
        default:   seqQ <= SEQ_IDLE;
      endcase

      if (abortNow || startNow || strb.cpuCancel) begin
        nextValid <= 1'b0;
      end else if (strb.promote) begin
        nextValid <= 1'b1;
        nextIdx   <= candIdx;
      end
    end
  end

  // R3: the scheduled buffer is always shown busy
  p_sched_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    nextValid |-> busyVec[nextIdx]);

  // R4: nothing is scheduled before the CRC field of the running frame
  p_closed_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ == SEQ_FRAME) |-> !nextValid);

  // R6: the buffer on the bus stays busy for the whole frame
  p_cur_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> busyVec[curIdx]);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9: while recovering, nothing is busy or scheduled
  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (seqQ == SEQ_HALT) |-> (!nextValid && busyVec == '0));

endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_txs_pkg::*;
#(
  parameter int NUM_BUF = 8,
  localparam int IDX_W  = $clog2(NUM_BUF)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuWrEn,
  input  logic [IDX_W-1:0]     cpuWrIdx,
  input  logic [2:0]           cpuWrData,
  input  logic                 crcStart,
  input  logic                 frameStart,
  input  logic                 txOk,
  input  logic                 txFail,
  input  logic                 recoverDone,
  input  logic [NUM_BUF-1:0]   rtrMatch,
  output logic [3*NUM_BUF-1:0] statusFlat,
  output logic [IDX_W-1:0]     curIdx,
  output logic [IDX_W-1:0]     nextIdx,
  output logic                 nextValid,
  output logic                 doneValid,
  output logic [IDX_W-1:0]     doneIdx
);

  strobes_t           strb;
  txMode_e            wrMode;
  logic [NUM_BUF-1:0] busyVec;
  logic               candValid;
  logic [IDX_W-1:0]   candIdx;

  // bit 2 of the written value is the busy indication and is ignored
  assign wrMode = txMode_e'(cpuWrData[1:0]);

  can_txs_control #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_ctrl (
    .clk, .rstN, .cpuWrEn, .cpuWrIdx, .cpuWrMode(wrMode),
    .crcStart, .frameStart, .txOk, .txFail, .recoverDone,
    .busyVec, .candValid, .candIdx, .strb,
    .curIdx, .nextIdx, .nextValid, .doneValid, .doneIdx
  );

  can_txs_datapath #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) i_dp (
    .clk, .rstN, .strb, .wrIdx(cpuWrIdx), .wrMode,
    .curIdx, .nextIdx, .rtrMatch,
    .statusFlat, .busyVec, .candValid, .candIdx
  );

endmodule

// File: tb/test_can_tx_sched.sv
module test_can_tx_sched;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cpuWrEn;
  logic [2:0]  cpuWrIdx;
  logic [2:0]  cpuWrData;
  logic        crcStart, frameStart, txOk, txFail, recoverDone;
  logic [7:0]  rtrMatch;
  logic [23:0] statusFlat;
  logic [2:0]  curIdx, nextIdx, doneIdx;
  logic        nextValid, doneValid;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  can_tx_sched #(.NUM_BUF(8)) i_can_tx_sched (
    .clk, .rstN, .cpuWrEn, .cpuWrIdx, .cpuWrData,
    .crcStart, .frameStart, .txOk, .txFail, .recoverDone, .rtrMatch,
    .statusFlat, .curIdx, .nextIdx, .nextValid, .doneValid, .doneIdx
  );

  // ev bits: [4] crcStart [3] frameStart [2] txOk [1] txFail [0] recoverDone
  typedef struct packed {
    logic       wrEn;
    logic [2:0] wrIdx;
    logic [2:0] wrData;
    logic [4:0] ev;
    logic [7:0] rtr;
    logic [2:0] chkIdx;
    logic [2:0] chkSt;
    logic       nv;
    logic [2:0] ni;
    logic [2:0] cur;
    logic       dn;
    logic [2:0] dni;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{1,5,1,5'b00000,8'h00, 5,1, 0,0,0, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 5,5, 1,5,0, 0,0, 3},
    '{1,2,1,5'b00000,8'h00, 2,1, 1,5,0, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 5,1, 1,2,0, 0,0, 5},
    '{0,0,0,5'b01000,8'h00, 2,5, 0,0,2, 0,0, 6},
    '{0,0,0,5'b00000,8'h00, 5,1, 0,0,2, 0,0, 4},
    '{0,0,0,5'b10000,8'h00, 5,1, 0,0,2, 0,0, 4},
    '{0,0,0,5'b00000,8'h00, 2,5, 1,5,2, 0,0, 6},
    '{1,5,0,5'b00000,8'h00, 5,0, 0,0,2, 0,0, 7},
    '{1,6,1,5'b00000,8'h00, 6,1, 0,0,2, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 6,5, 1,6,2, 0,0, 3},
    '{0,0,0,5'b00100,8'h00, 2,0, 1,6,2, 1,2, 8},
    '{0,0,0,5'b01000,8'h00, 6,5, 0,0,6, 0,0, 6},
    '{1,6,0,5'b00000,8'h00, 6,5, 0,0,6, 0,0, 7},
    '{1,1,1,5'b00000,8'h00, 1,1, 0,0,6, 0,0, 2},
    '{0,0,0,5'b00010,8'h00, 6,1, 0,0,6, 0,0, 9},
    '{0,0,0,5'b00000,8'h00, 1,1, 0,0,6, 0,0, 9},
    '{0,0,0,5'b00001,8'h00, 1,1, 0,0,6, 0,0, 9},
    '{0,0,0,5'b00000,8'h00, 1,5, 1,1,6, 0,0, 9},
    '{0,0,0,5'b01000,8'h00, 1,5, 0,0,1, 0,0, 6},
    '{0,0,0,5'b00100,8'h00, 1,0, 0,0,1, 1,1, 8},
    '{0,0,0,5'b00000,8'h00, 6,5, 1,6,1, 0,0, 9},
    '{0,0,0,5'b01000,8'h00, 6,5, 0,0,6, 0,0, 6},
    '{0,0,0,5'b00100,8'h00, 6,0, 0,0,6, 1,6, 8},
    '{1,3,2,5'b00000,8'h00, 3,2, 0,0,6, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 3,2, 0,0,6, 0,0,10},
    '{0,0,0,5'b00000,8'h08, 3,3, 0,0,6, 0,0,10},
    '{0,0,0,5'b00000,8'h00, 3,7, 1,3,6, 0,0,10},
    '{0,0,0,5'b01000,8'h00, 3,7, 0,0,3, 0,0, 6},
    '{0,0,0,5'b00100,8'h00, 3,2, 0,0,3, 1,3, 8},
    '{1,4,3,5'b00000,8'h00, 4,3, 0,0,3, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 4,7, 1,4,3, 0,0, 3},
    '{0,0,0,5'b01000,8'h00, 4,7, 0,0,4, 0,0, 6},
    '{0,0,0,5'b00100,8'h00, 4,2, 0,0,4, 1,4, 8},
    '{1,0,5,5'b00000,8'h00, 0,1, 0,0,4, 0,0, 2},
    '{0,0,0,5'b00000,8'h00, 0,5, 1,0,4, 0,0, 3},
    '{1,0,4,5'b00000,8'h00, 0,0, 0,0,4, 0,0, 7},
    '{0,0,0,5'b00000,8'h81, 7,0, 0,0,4, 0,0,10}
  };

  function automatic string tagName(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [2:0] stOf(input logic [2:0] idx);
    return statusFlat[3*idx +: 3];
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic wrEn, input logic [2:0] idx, input logic [2:0] data,
                       input logic [4:0] ev, input logic [7:0] rtr);
    cpuWrEn     = wrEn;
    cpuWrIdx    = idx;
    cpuWrData   = data;
    crcStart    = ev[4];
    frameStart  = ev[3];
    txOk        = ev[2];
    txFail      = ev[1];
    recoverDone = ev[0];
    rtrMatch    = rtr;
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    cpuWrEn = 0; cpuWrIdx = 0; cpuWrData = 0;
    crcStart = 0; frameStart = 0; txOk = 0; txFail = 0; recoverDone = 0;
    rtrMatch = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "statusFlat", int'(statusFlat), 0);
    chk("R1", "nextValid", int'(nextValid), 0);
    chk("R1", "doneValid", int'(doneValid), 0);

    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].wrEn, VECS[v].wrIdx, VECS[v].wrData, VECS[v].ev, VECS[v].rtr);
      chk(tagName(VECS[v].req), $sformatf("row %0d status", v),
          int'(stOf(VECS[v].chkIdx)), int'(VECS[v].chkSt));
      chk(tagName(VECS[v].req), $sformatf("row %0d nextValid", v),
          int'(nextValid), int'(VECS[v].nv));
      if (VECS[v].nv)
        chk(tagName(VECS[v].req), $sformatf("row %0d nextIdx", v),
            int'(nextIdx), int'(VECS[v].ni));
      chk(tagName(VECS[v].req), $sformatf("row %0d curIdx", v),
          int'(curIdx), int'(VECS[v].cur));
      chk(tagName(VECS[v].req), $sformatf("row %0d doneValid", v),
          int'(doneValid), int'(VECS[v].dn));
      if (VECS[v].dn)
        chk(tagName(VECS[v].req), $sformatf("row %0d doneIdx", v),
            int'(doneIdx), int'(VECS[v].dni));
    end

    // R6: frameStart with nothing requested is ignored
    drive(0, 0, 0, 5'b01000, 8'h00);
    chk("R6", "curIdx after idle frameStart", int'(curIdx), 4);
    drive(0, 0, 0, 5'b00000, 8'h00);
    chk("R6", "no busy after idle frameStart", int'(statusFlat & 24'o44444444), 0);

    // R5: a higher-index request does not displace the scheduled buffer
    drive(1, 2, 1, 5'b00000, 8'h00);
    drive(0, 0, 0, 5'b00000, 8'h00);
    drive(1, 6, 1, 5'b00000, 8'h00);
    drive(0, 0, 0, 5'b00000, 8'h00);
    chk("R5", "nextIdx kept", int'(nextIdx), 2);
    chk("R5", "higher index still pending", int'(stOf(3'd6)), 1);
    drive(0, 0, 0, 5'b01000, 8'h00);
    drive(0, 0, 0, 5'b00100, 8'h00);
    chk("R8", "done index low", int'(doneIdx), 2);
    drive(0, 0, 0, 5'b00000, 8'h00);
    chk("R3", "remaining request selected", int'(nextIdx), 6);
    drive(0, 0, 0, 5'b01000, 8'h00);
    drive(0, 0, 0, 5'b00100, 8'h00);
    chk("R8", "done index high", int'(doneIdx), 6);
    chk("R8", "status after done", int'(stOf(3'd6)), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

endmodule